// File: doc/BRIEF.md
# Threshold-Match Associative Memory

This block is a small associative store of score entries, each held at a fixed address. A command port accepts one of three operations per cycle. A write puts a score at an address and marks that slot as valid. A read returns the score held at an address. A search broadcasts a score to every slot in parallel.

In a search, each valid slot whose stored score is at most the broadcast score, compared as unsigned numbers, becomes a responder. The response then carries two things. The first is the address of the lowest-numbered responder rather than score data. The second is a two-bit class telling the requester whether nobody, exactly one slot, or several slots responded. All comparisons, the selection of one address and the classification happen within one cycle. The response register is loaded at the same edge that accepts the command.

The number of slots and the score width are parameters. The default is eight slots of 256-bit scores.

Top module: `thrcam_top`

## Requirements
- R1: While reset is held, rsp_valid, rsp_data and rsp_class are all zero. After reset, no slot is valid, so a search for the all-ones score reports class 00 with data zero.
- R2: rsp_valid is high in the cycle after every cycle in which cmd_valid is high. It is low in the cycle after every cycle in which cmd_valid is low.
- R3: A write (cmd_op 01) stores cmd_score at cmd_addr and marks the slot valid. The new value is seen by a read or search issued on the next cycle.
- R4: A read (cmd_op 00) returns the score stored at cmd_addr on rsp_data with class 00. A slot never written since reset reads as zero.
- R5: In a search (cmd_op 10), a slot is a responder when it is valid and its score is unsigned less than or equal to cmd_score. Equality counts as a match.
- R6: The search class is 00 for no responder, 01 for exactly one responder and 10 for more than one responder. The code 11 never appears on rsp_class while rsp_valid is high.
- R7: A search puts the lowest-numbered responder's index, zero-extended, on rsp_data. When there is no responder, rsp_data is zero.
- R8: Writing to a slot that is already valid replaces its score. A write's response carries data zero and class 00.
- R9: The reserved code cmd_op 11 changes no slot. It still produces a response, with data zero and class 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 search, 11 reserved |
| cmd_addr | input | AW | Slot address for read and write |
| cmd_score | input | SCORE_W | Score to write, or broadcast score for a search |
| rsp_valid | output | 1 | Response pulse, one cycle after a command |
| rsp_data | output | SCORE_W | Read score, or responder index for a search |
| rsp_class | output | 2 | Responder count class for a search |

## Verification
Every result is due in the cycle that directly follows the command, because only one register separates the command inputs from rsp_valid, rsp_data and rsp_class. A write changes the slots at that same edge, so the next command already sees it.

The bench drives inputs on the falling edge. On the following falling edge, after exactly one rising edge, it compares all three outputs against a behavioural model. The model computes the expected response from its state before that edge, and only then applies the write. Idle cycles are checked the same way, for a low rsp_valid.

// File: rtl/thrcam_pkg.sv
package thrcam_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_SEARCH = 2'b10,
    OP_RSVD   = 2'b11
  } thr_op_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_ONE  = 2'b01,
    CLS_MANY = 2'b10
  } thr_cls_e;

  // Classify a responder set from its "any" and "more than one" flags.
  function automatic thr_cls_e classify(input logic any_hit, input logic many_hit);
    if (many_hit)     return CLS_MANY;
    else if (any_hit) return CLS_ONE;
    else              return CLS_NONE;
  endfunction

endpackage

// File: rtl/thrcam_store.sv
module thrcam_store #(
  parameter int ENTRIES = 8,
  parameter int SCORE_W = 256,
  parameter int AW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [SCORE_W-1:0] wr_data,
  input  logic [AW-1:0]      rd_addr,
  input  logic [SCORE_W-1:0] key,
  output logic [SCORE_W-1:0] rd_data,
  output logic [ENTRIES-1:0] hit_vec
);

  logic [ENTRIES-1:0] valid_q;
  logic [SCORE_W-1:0] score_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (wr_addr == AW'(i)) valid_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (wr_addr == AW'(i)) score_q[i] <= wr_data;
    end
  end

  // One unsigned comparator per slot.
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (score_q[g] <= key);
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_addr == AW'(i) && valid_q[i]) rd_data = score_q[i];
  end

  // R3
  wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) < ENTRIES) |=> valid_q[$past(wr_addr)]);

endmodule

// File: rtl/thrcam_resolve.sv
module thrcam_resolve #(
  parameter int ENTRIES = 8,
  parameter int AW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic [AW-1:0]      first_idx,
  output logic               any_hit,
  output logic               many_hit
);

  // Mask of all slot positions strictly below idx.
  function automatic logic [ENTRIES-1:0] below_mask(input logic [AW-1:0] idx);
    logic [ENTRIES-1:0] m;
    m = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (AW'(i) < idx) m[i] = 1'b1;
    return m;
  endfunction

  // Fixed priority: the lowest set bit wins.
  always_comb begin
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) first_idx = AW'(i);
  end

  assign any_hit  = |hit_vec;
  // Clearing the lowest set bit leaves something iff two or more were set.
  assign many_hit = |(hit_vec & (hit_vec - ENTRIES'(1)));

  // R7
  first_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[first_idx]);

  // R7
  first_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & below_mask(first_idx)) == '0));

  // R6
  many_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    many_hit == ($countones(hit_vec) > 1));

endmodule

// File: rtl/thrcam_top.sv
module thrcam_top
  import thrcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SCORE_W = 256,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [AW-1:0]      cmd_addr,
  input  logic [SCORE_W-1:0] cmd_score,
  output logic               rsp_valid,
  output logic [SCORE_W-1:0] rsp_data,
  output logic [1:0]         rsp_class
);

  logic               is_wr;
  logic [SCORE_W-1:0] rd_data;
  logic [ENTRIES-1:0] hit_vec;
  logic [AW-1:0]      first_idx;
  logic               any_hit;
  logic               many_hit;
  logic [SCORE_W-1:0] nxt_data;
  thr_cls_e           nxt_class;

  assign is_wr = cmd_valid && (thr_op_e'(cmd_op) == OP_WRITE);

  thrcam_store #(.ENTRIES(ENTRIES), .SCORE_W(SCORE_W), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (is_wr),
    .wr_addr (cmd_addr),
    .wr_data (cmd_score),
    .rd_addr (cmd_addr),
    .key     (cmd_score),
    .rd_data (rd_data),
    .hit_vec (hit_vec)
  );

  thrcam_resolve #(.ENTRIES(ENTRIES), .AW(AW)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vec   (hit_vec),
    .first_idx (first_idx),
    .any_hit   (any_hit),
    .many_hit  (many_hit)
  );

  always_comb begin
    nxt_data  = '0;
    nxt_class = CLS_NONE;
    case (thr_op_e'(cmd_op))
      OP_READ:   nxt_data = rd_data;
      OP_SEARCH: begin
        if (any_hit) nxt_data[AW-1:0] = first_idx;
        nxt_class = classify(any_hit, many_hit);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_class <= CLS_NONE;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_data  <= nxt_data;
        rsp_class <= nxt_class;
      end
    end
  end

  // R2
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  // R6
  class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_class != 2'b11));

  // R7
  none_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SEARCH && !any_hit) |=> (rsp_data == '0));

  // R8
  write_rsp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> (rsp_data == '0 && rsp_class == CLS_NONE));

endmodule

// File: tb/thrcam_top_bench.sv
module thrcam_top_bench;

  localparam int N  = 8;
  localparam int W  = 256;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0]  cmd_score = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;
  logic [1:0]    rsp_class;

  int tests  = 0;
  int failed = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_score [N];
  bit           m_valid [N];

  always #2 clk = ~clk;

  thrcam_top #(.ENTRIES(N), .SCORE_W(W)) u_thrcam_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_score(cmd_score), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_class(rsp_class)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a command at the current falling edge; check the response one edge later.
  task automatic cmd(input logic [1:0] op, input int addr, input logic [W-1:0] sc, input string req);
    logic [W-1:0] exp_d;
    logic [1:0]   exp_c;
    int           cnt;
    exp_d = '0;
    exp_c = 2'b00;
    if (op == 2'b00) begin
      if (m_valid[addr]) exp_d = m_score[addr];
    end else if (op == 2'b10) begin
      cnt = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_valid[i] && m_score[i] <= sc) begin
          cnt++;
          exp_d = W'(i);
        end
      exp_c = (cnt == 0) ? 2'b00 : (cnt == 1) ? 2'b01 : 2'b10;
    end
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = AW'(addr);
    cmd_score = sc;
    @(posedge clk);
    if (op == 2'b01) begin
      m_score[addr] = sc;
      m_valid[addr] = 1'b1;
    end
    @(negedge clk);
    check({req, " valid"}, W'(rsp_valid), W'(1));
    check({req, " data"},  rsp_data, exp_d);
    check({req, " class"}, W'(rsp_class), W'(exp_c));
  endtask

  task automatic idle(input string req);
    cmd_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({req, " idle"}, W'(rsp_valid), W'(0));
  endtask

  initial begin
    logic [W-1:0] big;
    logic [31:0]  lfsr;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      m_score[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1 rst valid", W'(rsp_valid), W'(0));
    check("R1 rst data",  rsp_data, '0);
    check("R1 rst class", W'(rsp_class), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    idle("R2");
    cmd(2'b10, 0, '1, "R1 empty search");
    cmd(2'b00, 3, '0, "R4 unwritten read");
    cmd(2'b01, 5, W'(100), "R3 R8 write");
    cmd(2'b10, 0, W'(99), "R5 below");
    cmd(2'b10, 0, W'(100), "R5 equal");
    cmd(2'b10, 0, '1, "R6 one");
    cmd(2'b01, 2, W'(200), "R3 write2");
    cmd(2'b01, 6, W'(50), "R3 write6");
    cmd(2'b10, 0, W'(150), "R7 many low");
    cmd(2'b10, 0, W'(300), "R7 many all");
    cmd(2'b10, 0, W'(50), "R6 single");
    cmd(2'b10, 0, W'(49), "R6 none");
    cmd(2'b00, 2, '0, "R4 read");
    idle("R2 gap");
    cmd(2'b11, 2, '0, "R9 reserved");
    cmd(2'b00, 2, '0, "R9 read after");
    cmd(2'b10, 0, '0, "R9 search zero");
    big = '0;
    big[W-1] = 1'b1;
    cmd(2'b01, 2, big, "R8 overwrite");
    cmd(2'b10, 0, W'(300), "R8 search");
    cmd(2'b00, 2, '0, "R8 read");
    cmd(2'b10, 0, big - 1'b1, "R5 wide below");
    cmd(2'b10, 0, big, "R5 wide equal");
    cmd(2'b01, 0, '0, "R3 write0");
    cmd(2'b10, 0, '0, "R7 zero key");
    idle("R2 end");
    lfsr = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[0])
        cmd(2'b01, int'(lfsr[3:1]), W'(lfsr[15:8]), "R3 mix write");
      else if (lfsr[4])
        cmd(2'b10, 0, W'(lfsr[15:8]), "R5 mix search");
      else
        cmd(2'b00, int'(lfsr[3:1]), '0, "R4 mix read");
      if (lfsr[20] && lfsr[21]) idle("R2 mix");
    end
    idle("R2 final");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule